// File: doc/BRIEF.md
# Flash Completion Poller

This block runs on the host side of a byte-wide flash device. Once a program or erase command has gone out, the block decides whether that operation succeeded, failed or is still running. It does this by reading the flash status byte again and again.

Any status read may land at any address, so the block needs no address of its own. It only asks for reads over a request/response port and judges each byte it receives.

The rule it applies is simple. Two successive reads whose toggle bit agrees mean the operation is complete. A toggle bit that changes means the device is still working, unless the limit flag was set in the newer read. In that case the block takes one more confirming pair of reads, because the toggle may have stopped at the same moment the flag rose.

A failure makes the block send the return-to-read command byte F0h on a separate write port. Each operation ends with single-cycle done, pass and fail pulses, together with a result code that stays put until the next start.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle. busy, rd_req_valid, wr_valid, done, pass and fail are all low, and result is 0 (none).
- R2: start sampled while idle begins a new poll, raises busy on the next cycle and clears result to 0. start sampled while busy has no effect.
- R3: Read port rules:
  - A read request, once raised, stays raised until rd_req_ready is sampled high.
  - At most one read is outstanding at a time.
  - A response is consumed only while a read is outstanding, so responses seen while idle are ignored.
- R4: Reads are taken in pairs. When bit 6 is equal in both reads of a pair, the block goes idle and pulses done and pass in the cycle after the second response. result then becomes 1 (pass).
- R5: When bit 6 differs within a pair and bit 5 of the second read is 0, a fresh pair of reads follows.
- R6: When bit 6 differs within a pair and bit 5 of the second read is 1, a confirming pair follows. If bit 6 is equal within that confirming pair, the outcome is pass.
- R7: When bit 6 still differs within the confirming pair, the block sends F0h on the write port. It then pulses done and fail in the cycle after the write handshake, and result becomes 2 (limit failure).
- R8: In erase mode (is_erase sampled with start), reads are repeated until bit 3 reads 1. Only after that does the first pair begin. These arming reads never form part of a pair.
- R9: Response budget:
  - A nonzero max_polls caps the number of responses in one poll.
  - If the response that reaches the cap settles nothing, the block sends F0h and ends with done and fail. result becomes 3 (timeout).
  - A pass or limit verdict on that same response wins over the timeout.
  - max_polls of 0 means no cap.
- R10: abort, sampled while a read is pending or in flight, takes effect when that read's response arrives. The block then goes idle with no done, pass or fail pulse and result 0. The next start begins from a fresh first read of a pair.
- R11: done, pass and fail are single-cycle pulses. result holds its value from the end of a poll until the next start.
- R12: Write port rules:
  - wr_data carries F0h while wr_valid is high.
  - wr_valid stays high until wr_ready is sampled.
  - wr_valid and rd_req_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (sampled while idle) |
| is_erase | input | 1 | Sampled with start; selects the arming phase on bit 3 |
| abort | input | 1 | Abandon the poll at the next consumed response |
| max_polls | input | CNT_W | Response budget per poll, 0 for unlimited |
| rd_req_valid | output | 1 | Status read requested |
| rd_req_ready | input | 1 | Flash side accepts the read request |
| rd_rsp_valid | input | 1 | Status byte present (no back-pressure) |
| rd_rsp_data | input | DATA_W | Status byte |
| wr_valid | output | 1 | Return-to-read command write pending |
| wr_ready | input | 1 | Flash side accepts the write |
| wr_data | output | DATA_W | Command byte, F0h |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | One-cycle end-of-poll pulse |
| pass | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| result | output | 2 | Held outcome: 0 none, 1 pass, 2 limit failure, 3 timeout |

## Verification
A corrupted pair index or held toggle value shows up as a wrong number of read handshakes. The bench catches this at the end of the scenario, when the scripted status bytes run short or are left over. It also shows up as a done pulse that arrives one or more pairs early or late against the cycle-accurate reference.

A lost confirming-pair flag turns a limit failure into an endless poll or a premature pass. A budget counter that is off by one moves the timeout by exactly one response.

A sticky abort flag, or an arming flag that leaks from one poll to the next, shows up in the very next scenario as a missing pulse or extra reads.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_CMD  = 2'd3
  } poll_state_t;

  typedef enum logic [1:0] {
    RES_NONE         = 2'd0,
    RES_PASS         = 2'd1,
    RES_FAIL_LIMIT   = 2'd2,
    RES_FAIL_TIMEOUT = 2'd3
  } poll_result_t;

  typedef enum logic [2:0] {
    V_ARM_HOLD = 3'd0,
    V_ARM_GO   = 3'd1,
    V_FIRST    = 3'd2,
    V_AGAIN    = 3'd3,
    V_RECHECK  = 3'd4,
    V_PASS     = 3'd5,
    V_FAIL     = 3'd6
  } verdict_t;

endpackage

// File: rtl/fp_judge.sv
module fp_judge
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT  = 5,
  parameter int ARMED_BIT  = 3
) (
  input  logic              arming,
  input  logic              second,
  input  logic              rechk,
  input  logic [DATA_W-1:0] held,
  input  logic [DATA_W-1:0] data,
  output verdict_t          verdict
);

  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] LIM_MASK = DATA_W'(1) << LIMIT_BIT;
  localparam logic [DATA_W-1:0] ARM_MASK = DATA_W'(1) << ARMED_BIT;

  logic toggled;
  logic limit_seen;
  logic armed_seen;

  assign toggled    = |((data ^ held) & TOG_MASK);
  assign limit_seen = |(data & LIM_MASK);
  assign armed_seen = |(data & ARM_MASK);

  always_comb begin
    if (arming)          verdict = armed_seen ? V_ARM_GO : V_ARM_HOLD;
    else if (!second)    verdict = V_FIRST;
    else if (!toggled)   verdict = V_PASS;
    else if (rechk)      verdict = V_FAIL;
    else if (limit_seen) verdict = V_RECHECK;
    else                 verdict = V_AGAIN;
  end

endmodule

// File: rtl/fp_budget.sv
module fp_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             exhausted
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt  = {1'b0, cnt} + ONE;
  assign exhausted = (limit != '0) && (next_cnt == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (clear)                   cnt <= '0;
    else if (bump && (cnt != '1))     cnt <= next_cnt[CNT_W-1:0];
  end

endmodule

// File: rtl/fp_seq.sv
module fp_seq
  import flash_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_erase,
  input  logic              abort,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              wr_ready,
  input  verdict_t          verdict,
  input  logic              exhausted,
  output logic              arming,
  output logic              second,
  output logic              rechk,
  output logic [DATA_W-1:0] held,
  output logic              budget_clear,
  output logic              bump,
  output logic              rd_req_valid,
  output logic              wr_valid,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [1:0]        result
);

  poll_state_t  st;
  poll_result_t res_q;
  poll_result_t fail_code_q;
  logic         abort_pend;
  logic         done_q, pass_q, fail_q;
  logic         take;
  logic         quit;

  assign take         = (st == ST_RD_WAIT) && rd_rsp_valid;
  assign quit         = take && (abort_pend || abort);
  assign bump         = take;
  assign budget_clear = (st == ST_IDLE) && start;

  assign rd_req_valid = (st == ST_RD_REQ);
  assign wr_valid     = (st == ST_WR_CMD);
  assign busy         = (st != ST_IDLE);
  assign done         = done_q;
  assign pass         = pass_q;
  assign fail         = fail_q;
  assign result       = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      res_q       <= RES_NONE;
      fail_code_q <= RES_NONE;
      abort_pend  <= 1'b0;
      arming      <= 1'b0;
      second      <= 1'b0;
      rechk       <= 1'b0;
      held        <= '0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st         <= ST_RD_REQ;
            res_q      <= RES_NONE;
            abort_pend <= 1'b0;
            arming     <= is_erase;
            second     <= 1'b0;
            rechk      <= 1'b0;
          end
        end
        ST_RD_REQ: begin
          if (abort)        abort_pend <= 1'b1;
          if (rd_req_ready) st <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (quit) begin
            st <= ST_IDLE;
          end else if (take) begin
            if (verdict == V_PASS) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
              pass_q <= 1'b1;
              res_q  <= RES_PASS;
            end else if (verdict == V_FAIL) begin
              st          <= ST_WR_CMD;
              fail_code_q <= RES_FAIL_LIMIT;
            end else if (exhausted) begin
              st          <= ST_WR_CMD;
              fail_code_q <= RES_FAIL_TIMEOUT;
            end else begin
              st <= ST_RD_REQ;
              case (verdict)
                V_ARM_GO: begin
                  arming <= 1'b0;
                  second <= 1'b0;
                end
                V_FIRST: begin
                  held   <= rd_rsp_data;
                  second <= 1'b1;
                end
                V_AGAIN:   second <= 1'b0;
                V_RECHECK: begin
                  second <= 1'b0;
                  rechk  <= 1'b1;
                end
                default: ;
              endcase
            end
          end else if (abort) begin
            abort_pend <= 1'b1;
          end
        end
        ST_WR_CMD: begin
          if (wr_ready) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            fail_q <= 1'b1;
            res_q  <= fail_code_q;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid);

  // R12
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);

  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  verdict_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));

  // R7
  fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> $past(wr_valid && wr_ready));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(result));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && (result == 2'd0));

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                CNT_W      = 16,
  parameter int                TOGGLE_BIT = 6,
  parameter int                LIMIT_BIT  = 5,
  parameter int                ARMED_BIT  = 3,
  parameter logic [DATA_W-1:0] RESET_CMD  = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_erase,
  input  logic              abort,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [1:0]        result
);

  verdict_t          verdict;
  logic              exhausted;
  logic              arming, second, rechk;
  logic [DATA_W-1:0] held;
  logic              budget_clear, bump;

  assign wr_data = RESET_CMD;

  fp_judge #(
    .DATA_W    (DATA_W),
    .TOGGLE_BIT(TOGGLE_BIT),
    .LIMIT_BIT (LIMIT_BIT),
    .ARMED_BIT (ARMED_BIT)
  ) u_judge (
    .arming (arming),
    .second (second),
    .rechk  (rechk),
    .held   (held),
    .data   (rd_rsp_data),
    .verdict(verdict)
  );

  fp_budget #(
    .CNT_W(CNT_W)
  ) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (budget_clear),
    .bump     (bump),
    .limit    (max_polls),
    .exhausted(exhausted)
  );

  fp_seq #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_erase    (is_erase),
    .abort       (abort),
    .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data (rd_rsp_data),
    .wr_ready    (wr_ready),
    .verdict     (verdict),
    .exhausted   (exhausted),
    .arming      (arming),
    .second      (second),
    .rechk       (rechk),
    .held        (held),
    .budget_clear(budget_clear),
    .bump        (bump),
    .rd_req_valid(rd_req_valid),
    .wr_valid    (wr_valid),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .result      (result)
  );

endmodule

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0, is_erase = 1'b0, abort = 1'b0;
  logic [15:0] max_polls = '0;
  logic        rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, wr_ready = 1'b0;
  logic [7:0]  rd_rsp_data = '0;
  logic        rd_req_valid, wr_valid, busy, done, pass, fail;
  logic [7:0]  wr_data;
  logic [1:0]  result;

  flash_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_erase(is_erase), .abort(abort),
    .max_polls(max_polls), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .busy(busy), .done(done), .pass(pass),
    .fail(fail), .result(result)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int m_st = 0;               // 0 idle, 1 request, 2 waiting, 3 command write
  bit m_arm, m_second, m_rechk, m_abort, m_held6;
  int m_cnt, m_code;
  bit e_busy, e_rv, e_wv, e_done, e_pass, e_fail;
  int e_res = 0;

  // flash responder
  byte unsigned sq[$];
  int lat = -1;
  bit stray_req = 0;
  int cyc = 0;
  int n_rsp, n_under, n_done, n_pass, n_fail;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int outcome;  // 0 keep polling, 1 pass, 2 fail
    e_done = 0; e_pass = 0; e_fail = 0;
    case (m_st)
      0: if (start) begin
        m_st = 1; e_res = 0; m_arm = is_erase; m_second = 0;
        m_rechk = 0; m_abort = 0; m_cnt = 0;
      end
      1: begin
        if (abort) m_abort = 1;
        if (rd_req_ready) m_st = 2;
      end
      2: if (rd_rsp_valid) begin
        m_cnt++;
        if (m_abort || abort) m_st = 0;
        else begin
          outcome = 0;
          if (m_arm) begin
            if (rd_rsp_data[3]) begin m_arm = 0; m_second = 0; end
          end else if (!m_second) begin
            m_held6 = rd_rsp_data[6]; m_second = 1;
          end else if (rd_rsp_data[6] == m_held6) outcome = 1;
          else if (m_rechk) begin outcome = 2; m_code = 2; end
          else if (rd_rsp_data[5]) begin m_rechk = 1; m_second = 0; end
          else m_second = 0;
          if (outcome == 0 && max_polls != 0 && m_cnt == int'(max_polls)) begin
            outcome = 2; m_code = 3;
          end
          if (outcome == 1) begin m_st = 0; e_done = 1; e_pass = 1; e_res = 1; end
          else if (outcome == 2) m_st = 3;
          else m_st = 1;
        end
      end else if (abort) m_abort = 1;
      3: if (wr_ready) begin m_st = 0; e_done = 1; e_fail = 1; e_res = m_code; end
      default: ;
    endcase
    e_busy = (m_st != 0); e_rv = (m_st == 1); e_wv = (m_st == 3);
  endtask

  task automatic tick();
    chk(busy == e_busy, "R2", "busy", busy, e_busy);
    chk(rd_req_valid == e_rv, "R3", "rd_req_valid", rd_req_valid, e_rv);
    chk(wr_valid == e_wv, "R12", "wr_valid", wr_valid, e_wv);
    if (wr_valid) chk(wr_data == 8'hF0, "R12", "wr_data", wr_data, 8'hF0);
    chk(done == e_done, "R11", "done", done, e_done);
    chk(pass == e_pass, "R4", "pass", pass, e_pass);
    chk(fail == e_fail, "R7", "fail", fail, e_fail);
    chk(int'(result) == e_res, "R11", "result", result, e_res);
    if (done) n_done++;
    if (pass) n_pass++;
    if (fail) n_fail++;
    rd_req_ready = (cyc % 3) != 2;
    wr_ready     = (cyc % 2) == 0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = 8'h00;
    if (stray_req) begin
      rd_rsp_valid = 1'b1;
      stray_req = 0;
    end else if (lat == 0) begin
      rd_rsp_valid = 1'b1;
      if (sq.size() > 0) rd_rsp_data = sq.pop_front();
      else n_under++;
      n_rsp++;
      lat = -1;
    end else if (lat > 0) lat--;
    if (rd_req_valid && rd_req_ready) lat = 2;
    model_step();
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input bit er, input int mx, input int abort_after,
                     input int restart_after, input int exp_res, input string req);
    bit ab_done = 0, rs_done = 0;
    n_rsp = 0; n_under = 0; n_done = 0; n_pass = 0; n_fail = 0;
    is_erase = er; max_polls = 16'(mx);
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int g = 0; g < 3000 && e_busy; g++) begin
      if (abort_after >= 0 && n_rsp == abort_after && !ab_done) begin
        abort = 1'b1; ab_done = 1;
      end
      if (restart_after >= 0 && n_rsp == restart_after && !rs_done) begin
        start = 1'b1; rs_done = 1;
      end
      tick();
      abort = 1'b0;
      start = 1'b0;
    end
    repeat (4) tick();
    chk(int'(result) == exp_res, req, "final result", result, exp_res);
    chk(n_done == (exp_res == 0 ? 0 : 1), req, "done pulses", n_done, exp_res == 0 ? 0 : 1);
    chk(n_pass == (exp_res == 1 ? 1 : 0), req, "pass pulses", n_pass, exp_res == 1 ? 1 : 0);
    chk(sq.size() == 0 && n_under == 0, req, "scripted reads left/extra",
        sq.size() + 100 * n_under, 0);
    sq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(rd_req_valid == 0, "R1", "rd_req_valid", rd_req_valid, 0);
    chk(wr_valid == 0, "R1", "wr_valid", wr_valid, 0);
    chk((done | pass | fail) == 0, "R1", "pulses", done | pass | fail, 0);
    chk(result == 0, "R1", "result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    sq = '{8'h40, 8'h40};                        run(0, 0, -1, -1, 1, "R4");
    sq = '{8'h40, 8'h00, 8'h00, 8'h00};          run(0, 0, -1, -1, 1, "R5");
    sq = '{8'h40, 8'h20, 8'h00, 8'h00};          run(0, 0, -1, -1, 1, "R6");
    sq = '{8'h40, 8'h20, 8'h00, 8'h40};          run(0, 0, -1, -1, 2, "R7");
    sq = '{8'h00, 8'h00, 8'h08, 8'h48, 8'h48};   run(1, 0, -1, -1, 1, "R8");
    sq = '{8'h40, 8'h00, 8'h40};                 run(0, 3, -1, -1, 3, "R9");
    sq = '{8'h40, 8'h40};                        run(0, 2, -1, -1, 1, "R9");
    for (int i = 0; i < 20; i++) begin sq.push_back(8'h40); sq.push_back(8'h00); end
    sq.push_back(8'h00); sq.push_back(8'h00);
    run(0, 0, -1, -1, 1, "R9");
    sq = '{8'h40, 8'h40};                        run(0, 0, 1, -1, 0, "R10");
    sq = '{8'h00, 8'h40, 8'h00, 8'h00};          run(0, 0, -1, -1, 1, "R10");
    sq = '{8'h40, 8'h00, 8'h00, 8'h00};          run(0, 0, -1, 1, 1, "R2");
    stray_req = 1;
    tick();
    sq = '{8'h40, 8'h40};                        run(0, 0, -1, -1, 1, "R3");
    // R11 result held while idle
    repeat (6) tick();
    chk(result == 2'd1, "R11", "held result", result, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule